// File: doc/BRIEF.md
# Frame-Triggered Peripheral-to-Memory DMA Channel

This block is one DMA channel that drains a peripheral data register into a linear buffer in memory. Software programs a fixed source address, a destination base address, the number of frames in a block and the number of 32-bit elements in each frame. Each pulse on the hardware request input moves one whole frame. For every element the channel reads once from the source and then writes once to the next destination word. The source address never changes. The destination address advances by four bytes per element and keeps advancing across frame boundaries.

Two sticky flags mark progress through the block. The half flag rises once half of the frames (rounded down) have been moved. The done flag rises once the last element of the last frame has been written. Each flag drives its own interrupt output through its own enable bit. With auto-initialize set, the channel reloads the destination base and the frame position at block end and keeps serving requests. This lets software use the two buffer halves as a ping-pong pair. Without auto-initialize, the channel clears its own enable bit at block end.

The memory side is a single-beat valid/ready master. While `mem_valid` is high, `mem_write`, `mem_addr` and `mem_wdata` hold steady until a cycle with `mem_ready` high completes the beat. Read data on `mem_rdata` is taken in that same cycle. The slave may stall for any number of cycles, and the channel never drops or repeats a beat.

Top module: `dma_frame_chan`

## Requirements
- R1: After reset, every register reads 0 (source at address 0, destination 1, frame count 2, element count 3, control 4, status 5), both interrupt outputs are low and `mem_valid` is low.
- R2: One request moves exactly one frame: element-count read/write beat pairs, after which `mem_valid` drops and no further beats occur without a new request.
- R3: Every read beat uses the source register address. Write beat k of a block (counted from 0) uses destination base + 4·k, continuing across frames.
- R4: Per element, one read is followed by one write that carries the data returned by that read. Address, direction and write data are held while `mem_valid` is high and `mem_ready` is low.
- R5: Status bit 0 (half) is set when floor(F/2) frames of an F-frame block are finished, for F of 2 or more, and not before.
- R6: Status bit 1 (done) is set when the last element of the last frame is written.
- R7: Control bit 2 enables `irq_half` and control bit 3 enables `irq_done` independently. Each output equals its flag ANDed with its enable.
- R8: Status flags stay set until software writes 1 to the same bit of the status register. Writing 0 to a bit leaves it unchanged.
- R9: With control bit 1 (auto-initialize) set, control bit 0 (enable) stays set at block end, and the next block's first write goes to the destination base again.
- R10: With auto-initialize clear, the enable bit reads 0 after block end and requests are ignored. Setting the enable bit again restarts at the destination base.
- R11: A request that arrives while a frame is in progress is held and served afterwards. A further request while one is already held sets sticky status bit 2 (overrun) and is dropped.
- R12: While the enable bit is 0, requests start no transfer and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` (combinational) |
| hw_req | input | 1 | Hardware request pulse, one frame per pulse |
| mem_valid | output | 1 | Memory beat valid |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Beat accepted (ready) |
| mem_rdata | input | 32 | Read data, valid while `mem_ready` is high on a read beat |
| irq_half | output | 1 | Half-block interrupt |
| irq_done | output | 1 | Block-complete interrupt |

## Verification
The bench checks the frame boundary. A channel that miscounts elements would keep issuing beats after the frame ends or stop one element short. It checks the half point of an odd frame count, where a design that rounds up would flag half a frame late. It checks destination continuity across frames and across an auto-initialize wrap, which would catch a design that restarts the address on each frame or never rewinds it. Further scenarios stall the memory slave to catch data taken in the wrong cycle. They send three back-to-back requests to catch a design that queues more than one request or loses the held one. They also confirm that a channel that disabled itself at block end ignores further requests.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} eng_state_t;

  localparam logic [2:0] RA_SRC = 3'd0;
  localparam logic [2:0] RA_DST = 3'd1;
  localparam logic [2:0] RA_FRM = 3'd2;
  localparam logic [2:0] RA_ELM = 3'd3;
  localparam logic [2:0] RA_CTL = 3'd4;
  localparam logic [2:0] RA_STS = 3'd5;

  localparam int CB_EN   = 0;
  localparam int CB_AUTO = 1;
  localparam int CB_HIE  = 2;
  localparam int CB_DIE  = 3;

  localparam int SB_HALF = 0;
  localparam int SB_DONE = 1;
  localparam int SB_OVR  = 2;
endpackage

// File: rtl/dma_chan_req.sv
module dma_chan_req (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hw_req_i,
  input  logic take_i,
  output logic pend_o,
  output logic ovr_evt_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (!en_i)     pend_q <= 1'b0;
    else if (hw_req_i)  pend_q <= 1'b1;
    else if (take_i)    pend_q <= 1'b0;
  end

  assign pend_o    = pend_q;
  assign ovr_evt_o = en_i && hw_req_i && pend_q && !take_i;

  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> pend_q); // R11
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] frames_o,
  output logic [CW-1:0] elems_o,
  output logic          en_o,
  output logic          auto_o,
  output logic          load_o,
  input  logic          half_evt_i,
  input  logic          done_evt_i,
  input  logic          ovr_evt_i,
  output logic          irq_half,
  output logic          irq_done
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] frm_q, elm_q;
  logic          en_q, auto_q, hie_q, die_q;
  logic          half_q, done_q, ovr_q;
  logic          wr_ctl, wr_sts;
  logic          unused_wbits;

  assign unused_wbits = ^reg_wdata;
  assign wr_ctl = reg_wr && (reg_addr == RA_CTL);
  assign wr_sts = reg_wr && (reg_addr == RA_STS);
  assign load_o = wr_ctl && reg_wdata[CB_EN] && !en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; frm_q <= '0; elm_q <= '0;
      auto_q <= 1'b0; hie_q <= 1'b0; die_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_SRC: src_q <= reg_wdata[AW-1:0];
        RA_DST: dst_q <= reg_wdata[AW-1:0];
        RA_FRM: frm_q <= reg_wdata[CW-1:0];
        RA_ELM: elm_q <= reg_wdata[CW-1:0];
        RA_CTL: begin
          auto_q <= reg_wdata[CB_AUTO];
          hie_q  <= reg_wdata[CB_HIE];
          die_q  <= reg_wdata[CB_DIE];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    en_q <= 1'b0;
    else if (done_evt_i && !auto_q) en_q <= 1'b0;
    else if (wr_ctl)               en_q <= reg_wdata[CB_EN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0; done_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      if (half_evt_i)                          half_q <= 1'b1;
      else if (wr_sts && reg_wdata[SB_HALF])   half_q <= 1'b0;
      if (done_evt_i)                          done_q <= 1'b1;
      else if (wr_sts && reg_wdata[SB_DONE])   done_q <= 1'b0;
      if (ovr_evt_i)                           ovr_q  <= 1'b1;
      else if (wr_sts && reg_wdata[SB_OVR])    ovr_q  <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_SRC: reg_rdata[AW-1:0] = src_q;
      RA_DST: reg_rdata[AW-1:0] = dst_q;
      RA_FRM: reg_rdata[CW-1:0] = frm_q;
      RA_ELM: reg_rdata[CW-1:0] = elm_q;
      RA_CTL: reg_rdata[3:0]    = {die_q, hie_q, auto_q, en_q};
      RA_STS: reg_rdata[2:0]    = {ovr_q, done_q, half_q};
      default: ;
    endcase
  end

  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign frames_o = frm_q;
  assign elems_o  = elm_q;
  assign en_o     = en_q;
  assign auto_o   = auto_q;
  assign irq_half = half_q && hie_q;
  assign irq_done = done_q && die_q;

  AST_HALF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q && !(wr_sts && reg_wdata[SB_HALF])) |=> half_q); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(wr_sts && reg_wdata[SB_OVR])) |=> ovr_q); // R11
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          auto_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] frames_i,
  input  logic [CW-1:0] elems_i,
  input  logic          pend_i,
  output logic          take_o,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          half_evt_o,
  output logic          done_evt_o
);
  localparam int STEP = DW / 8;

  eng_state_t    st_q;
  logic [AW-1:0] cur_dst_q;
  logic [CW-1:0] elem_q, frm_q;
  logic [DW-1:0] data_q;
  logic          wr_ack, last_elem;
  logic [CW-1:0] frm_next, half_pt;

  assign take_o    = (st_q == ST_IDLE) && en_i && pend_i;
  assign wr_ack    = (st_q == ST_WRITE) && mem_ready;
  assign last_elem = (elem_q == elems_i - CW'(1));
  assign frm_next  = frm_q + CW'(1);
  assign half_pt   = frames_i >> 1;

  assign half_evt_o = wr_ack && last_elem && (frames_i >= CW'(2)) && (frm_next == half_pt);
  assign done_evt_o = wr_ack && last_elem && (frm_next == frames_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cur_dst_q <= '0;
      elem_q    <= '0;
      frm_q     <= '0;
      data_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (load_i) begin
            cur_dst_q <= dst_i;
            frm_q     <= '0;
          end
          if (take_o) begin
            elem_q <= '0;
            st_q   <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ready) begin
            data_q <= mem_rdata;
            st_q   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_ready) begin
            cur_dst_q <= cur_dst_q + AW'(STEP);
            if (last_elem) begin
              st_q  <= ST_IDLE;
              frm_q <= frm_next;
              if (done_evt_o && auto_i) begin
                cur_dst_q <= dst_i;
                frm_q     <= '0;
              end
            end else begin
              elem_q <= elem_q + CW'(1);
              st_q   <= ST_READ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid = (st_q != ST_IDLE);
  assign mem_write = (st_q == ST_WRITE);
  assign mem_addr  = (st_q == ST_WRITE) ? cur_dst_q : src_i;
  assign mem_wdata = data_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write) && $stable(mem_addr) && $stable(mem_wdata))); // R4
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !en_i) |=> (st_q == ST_IDLE)); // R12
  AST_HALF_DONE_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(half_evt_o && done_evt_o)); // R5
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write && mem_ready) |=> (mem_valid && mem_write)); // R4
endmodule

// File: rtl/dma_frame_chan.sv
module dma_frame_chan #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          hw_req,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq_half,
  output logic          irq_done
);
  logic [AW-1:0] src, dst;
  logic [CW-1:0] frames, elems;
  logic          en, auto_init, load, pend, take;
  logic          half_evt, done_evt, ovr_evt;

  dma_chan_regs #(.DW(DW), .AW(AW), .CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_o(src), .dst_o(dst), .frames_o(frames), .elems_o(elems),
    .en_o(en), .auto_o(auto_init), .load_o(load),
    .half_evt_i(half_evt), .done_evt_i(done_evt), .ovr_evt_i(ovr_evt),
    .irq_half(irq_half), .irq_done(irq_done)
  );

  dma_chan_req req_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .hw_req_i(hw_req),
    .take_i(take), .pend_o(pend), .ovr_evt_o(ovr_evt)
  );

  dma_chan_engine #(.DW(DW), .AW(AW), .CW(CW)) eng_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .load_i(load), .auto_i(auto_init),
    .src_i(src), .dst_i(dst), .frames_i(frames), .elems_i(elems),
    .pend_i(pend), .take_o(take),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .half_evt_o(half_evt), .done_evt_o(done_evt)
  );
endmodule

// File: tb/dma_frame_chan_tb_top.sv
module dma_frame_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        hw_req;
  logic        mem_valid, mem_write, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq_half, irq_done;

  int n_chk = 0;
  int n_bad = 0;
  int stall = 0;
  int wait_cnt = 0;
  int rd_seq = 0;
  int log_n = 0;
  logic        log_wr   [0:63];
  logic [31:0] log_addr [0:63];
  logic [31:0] log_data [0:63];

  localparam logic [31:0] SRC_A = 32'h4000_0040;
  localparam logic [31:0] RD_BASE = 32'hA500_0000;

  always #4 clk = ~clk;

  dma_frame_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .irq_half(irq_half), .irq_done(irq_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // memory slave: ready decided at negedge, beat completes at next posedge
  initial begin
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_valid && wait_cnt >= stall) begin
        mem_ready = 1'b1;
        wait_cnt = 0;
        if (!mem_write) begin
          mem_rdata = RD_BASE + 32'(rd_seq);
          rd_seq++;
        end
        if (log_n < 64) begin
          log_wr[log_n]   = mem_write;
          log_addr[log_n] = mem_addr;
          log_data[log_n] = mem_write ? mem_wdata : mem_rdata;
        end
        log_n++;
      end else begin
        mem_ready = 1'b0;
        if (mem_valid) wait_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    hw_req = 1'b1;
    @(negedge clk);
    hw_req = 1'b0;
  endtask

  task automatic wait_beats(input int n);
    int t = 0;
    while (log_n < n && t < 3000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // check element beats [first_el, first_el+n) against dst0 + 4*k_el
  task automatic chk_elems(input string tag, input int first_el, input int n,
                           input logic [31:0] dst0, input int k0);
    for (int i = 0; i < n; i++) begin
      int r = 2 * (first_el + i);
      logic ok;
      ok = !log_wr[r] && log_wr[r+1] && (log_addr[r] == SRC_A) &&
           (log_data[r+1] == log_data[r]) &&
           (log_addr[r+1] == dst0 + 32'(4 * (k0 + i)));
      chk(tag, {31'b0, ok}, 32'd1);
      if (!ok) $display("  beat %0d: rd@%h wr@%h data %h/%h", r, log_addr[r],
                        log_addr[r+1], log_data[r], log_data[r+1]);
    end
  endtask

  task automatic clean_slate();
    wr_reg(3'd4, 32'd0);
    wr_reg(3'd5, 32'd7);
    stall = 0;
    log_n = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), v);
      chk($sformatf("R1 reg %0d after reset", a), v, 32'd0);
    end
    chk("R1 irq_half after reset", {31'b0, irq_half}, 32'd0);
    chk("R1 irq_done after reset", {31'b0, irq_done}, 32'd0);
    chk("R1 mem_valid after reset", {31'b0, mem_valid}, 32'd0);
  endtask

  task automatic t_single_block();
    logic [31:0] v;
    clean_slate();
    wr_reg(3'd0, SRC_A);
    wr_reg(3'd1, 32'h2000_0000);
    wr_reg(3'd2, 32'd2);
    wr_reg(3'd3, 32'd4);
    wr_reg(3'd4, 32'd13);           // en, half_ie, done_ie
    pulse_req();
    wait_beats(8);
    repeat (10) @(negedge clk);
    chk("R2 one frame beat count", 32'(log_n), 32'd8);
    chk("R2 idle after frame", {31'b0, mem_valid}, 32'd0);
    chk_elems("R3 R4 frame0 addresses/data", 0, 4, 32'h2000_0000, 0);
    rd_reg(3'd5, v);
    chk("R5 half flag after 1 of 2 frames", v, 32'd1);
    chk("R7 irq_half on", {31'b0, irq_half}, 32'd1);
    chk("R7 irq_done off", {31'b0, irq_done}, 32'd0);
    stall = 2;
    pulse_req();
    wait_beats(16);
    chk("R2 second frame beat count", 32'(log_n), 32'd16);
    chk_elems("R3 R4 frame1 stalled, continuing dst", 4, 4, 32'h2000_0000, 4);
    rd_reg(3'd5, v);
    chk("R6 done flag at block end", v, 32'd3);
    chk("R7 irq_done on", {31'b0, irq_done}, 32'd1);
    rd_reg(3'd4, v);
    chk("R10 enable cleared at block end", v, 32'd12);
    pulse_req();
    repeat (40) @(negedge clk);
    chk("R10 request ignored after self-disable", 32'(log_n), 32'd16);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr_reg(3'd5, 32'd0);
    rd_reg(3'd5, v);
    chk("R8 write 0 keeps flags", v, 32'd3);
    wr_reg(3'd5, 32'd1);
    rd_reg(3'd5, v);
    chk("R8 clear half only", v, 32'd2);
    chk("R8 irq_half drops after clear", {31'b0, irq_half}, 32'd0);
    chk("R8 irq_done stays", {31'b0, irq_done}, 32'd1);
    wr_reg(3'd5, 32'd2);
    rd_reg(3'd5, v);
    chk("R8 clear done", v, 32'd0);
  endtask

  task automatic t_reenable();
    log_n = 0;
    stall = 0;
    wr_reg(3'd4, 32'd13);
    pulse_req();
    wait_beats(8);
    chk("R10 beats after re-enable", 32'(log_n), 32'd8);
    chk_elems("R10 restart at destination base", 0, 4, 32'h2000_0000, 0);
  endtask

  task automatic t_autoinit();
    logic [31:0] v;
    clean_slate();
    wr_reg(3'd1, 32'h3000_0100);
    wr_reg(3'd2, 32'd3);
    wr_reg(3'd3, 32'd2);
    wr_reg(3'd4, 32'd7);            // en, auto, half_ie
    pulse_req();
    wait_beats(4);
    rd_reg(3'd5, v);
    chk("R5 half after floor(3/2)=1 frame", v, 32'd1);
    pulse_req();
    wait_beats(8);
    rd_reg(3'd5, v);
    chk("R6 no done before last frame", v, 32'd1);
    pulse_req();
    wait_beats(12);
    rd_reg(3'd5, v);
    chk("R6 done after third frame", v, 32'd3);
    chk("R7 irq_done masked", {31'b0, irq_done}, 32'd0);
    chk("R7 irq_half enabled", {31'b0, irq_half}, 32'd1);
    rd_reg(3'd4, v);
    chk("R9 enable kept with auto-init", v, 32'd7);
    chk_elems("R3 three frames linear", 0, 6, 32'h3000_0100, 0);
    pulse_req();
    wait_beats(16);
    chk("R9 next block serviced", 32'(log_n), 32'd16);
    chk_elems("R9 wrap to destination base", 6, 2, 32'h3000_0100, 0);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    clean_slate();
    wr_reg(3'd1, 32'h5000_0000);
    wr_reg(3'd2, 32'd4);
    wr_reg(3'd3, 32'd4);
    wr_reg(3'd4, 32'd3);            // en, auto
    stall = 5;
    pulse_req();
    repeat (4) @(negedge clk);
    pulse_req();
    repeat (2) @(negedge clk);
    pulse_req();
    wait_beats(16);
    repeat (200) @(negedge clk);
    chk("R11 held request served, extra dropped", 32'(log_n), 32'd16);
    chk_elems("R11 two frames linear", 0, 8, 32'h5000_0000, 0);
    rd_reg(3'd5, v);
    chk("R11 overrun and half set", v, 32'd5);
    wr_reg(3'd5, 32'd4);
    rd_reg(3'd5, v);
    chk("R11 overrun cleared by W1C", v, 32'd1);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    clean_slate();
    pulse_req();
    repeat (40) @(negedge clk);
    chk("R12 no beats while disabled", 32'(log_n), 32'd0);
    rd_reg(3'd5, v);
    chk("R12 no flags while disabled", v, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_addr = '0;
    reg_wdata = '0;
    hw_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_block();
    t_w1c();
    t_reenable();
    t_autoinit();
    t_overrun();
    t_disabled();
    summary();
    $finish;
  end
endmodule